// File: doc/BRIEF.md
# IR pulse-width capture receiver

This block takes a demodulated infrared input (low while a carrier burst is present, high while idle) and records the duration of each mark and each space as an 8-bit count of a programmable sample tick. A digital filter first rejects short glitches on the input. The accepted durations are then written into a bank of 32-bit capture words, four to a word. When a space has lasted 255 ticks the message is considered over. After a programmable number of further idle ticks the block sets an interrupt status bit, and it leaves the captured data untouched until software issues a restart.

Software configures the block through a flat word-addressed register interface, with a single-cycle write strobe and a combinational read port. Once the interrupt arrives, software reads the capture words, restarts the receiver and acknowledges the interrupt. Decoding of the durations into remote-control commands happens elsewhere.

Top module: `ir_capture`

## Requirements
- R1: After reset every configuration register, the interrupt status, all capture words and `irq` read zero.
- R2: A sample tick occurs every PERIOD+1 clocks, where PERIOD is address 1 bits 15:0. Each entry holds the number of ticks that a filtered level lasted. The first entry is a mark (input low), and entries then alternate mark, space, mark and so on.
- R3: Entry k is stored in capture word k/4, in bits 8*(k%4)+7 down to 8*(k%4). Capture word i reads at address 16+i, and unused entries read zero.
- R4: A mark longer than 255 ticks is stored as 0xFF and does not wrap.
- R5: When a space reaches 255 ticks, 0xFF is stored as the final entry and capture stops.
- R6: The interrupt status (address 5 bit 0) sets on the (K+1)-th sample tick after capture stops, where K is address 0 bits 15:8. It does not set before that tick.
- R7: When all 68 entries are filled without an end condition, capture stops and completion follows as in R6.
- R8: Once capture has stopped, further input activity leaves every capture word unchanged.
- R9: Writing 1 to address 3 bit 0 zeroes all capture words and re-arms the receiver to wait for the next mark. The interrupt status is left as it was.
- R10: `irq` is the interrupt status gated by the enable at address 4 bit 0. Writing 1 to address 5 bit 0 clears the status. A completion on the same cycle takes precedence over the clear.
- R11: A change of input level is accepted only after D consecutive sample ticks at the new level, where D is address 2 bits 4:0 and a value of 0 acts as 1. Shorter excursions have no effect on the recorded widths.
- R12: The sample tick runs only while both address 0 bit 0 (receiver on) and bit 1 (width detection on) are set. Otherwise nothing is captured and no completion occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Demodulated IR input, low during a mark |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | ADDR_W | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request, level |

## Verification
The bench builds the block with its defaults: 17 capture words and a 16-bit period field. It then programs a period of 3, so one sample tick lasts four clocks. At that rate the 255-tick space saturation, the 255-tick mark clamp and a full 68-entry overflow each take only a few thousand clocks, so every one of these limits is reached in a short directed run. Input edges are spaced by whole tick periods, which makes every expected width exact. This covers the de-glitch case and the check that completion does not come early.

// File: rtl/ir_capture.sv
module ir_capture #(
  parameter int NWORDS = 17,
  parameter int PER_W  = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ir_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              irq
);
  localparam int NENT   = NWORDS * 4;
  localparam int IDX_W  = $clog2(NENT + 1);
  localparam int WSEL_W = $clog2(NWORDS);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_FILT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_RST  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_CAP  = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] A_END  = ADDR_W'(16 + NWORDS);
  localparam logic [1:0] S_IDLE = 2'd0, S_RUN = 2'd1, S_WAIT = 2'd2, S_DONE = 2'd3;

  logic             rx_on, pw_on, ien, stat;
  logic [7:0]       ok_cnt;
  logic [PER_W-1:0] per, pc;
  logic [4:0]       dg, dgc;
  logic             s0, s1, flt;
  logic [1:0]       state;
  logic [IDX_W-1:0] idx;
  logic [7:0]       cnt, wcnt;
  logic [8*NENT-1:0] cap;

  wire run        = rx_on && pw_on;
  wire tick       = run && (pc >= per);
  wire restart_wr = wr_en && (wr_addr == A_RST) && wr_data[0];
  wire clr_wr     = wr_en && (wr_addr == A_STAT) && wr_data[0];

  wire [4:0] dg_eff = (dg == 5'd0) ? 5'd1 : dg;
  wire [5:0] dgc_nx = {1'b0, dgc} + 6'd1;
  wire       chg    = tick && (s1 != flt) && (dgc_nx >= {1'b0, dg_eff});
  wire [7:0] cinc   = (cnt == 8'hFF) ? cnt : cnt + 8'd1;
  wire       last   = (idx == IDX_W'(NENT - 1));
  wire       stat_set = tick && (state == S_WAIT) && (wcnt == ok_cnt) && !restart_wr;

  assign irq = stat && ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_on <= 1'b0; pw_on <= 1'b0; ok_cnt <= '0;
      per <= '0; dg <= '0; ien <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin rx_on <= wr_data[0]; pw_on <= wr_data[1]; ok_cnt <= wr_data[15:8]; end
        A_PER:  per <= wr_data[PER_W-1:0];
        A_FILT: dg  <= wr_data[4:0];
        A_IEN:  ien <= wr_data[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= 1'b0;
    else        stat <= stat_set || (stat && !clr_wr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pc <= '0;
    else if (!run) pc <= '0;
    else if (tick) pc <= '0;
    else           pc <= pc + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0 <= 1'b1; s1 <= 1'b1; flt <= 1'b1; dgc <= '0;
    end else begin
      s0 <= ir_in;
      s1 <= s0;
      if (tick) begin
        if (s1 == flt)  dgc <= '0;
        else if (chg) begin flt <= s1; dgc <= '0; end
        else            dgc <= dgc_nx[4:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; idx <= '0; cnt <= '0; wcnt <= '0; cap <= '0;
    end else if (restart_wr) begin
      state <= S_IDLE; idx <= '0; cnt <= '0; wcnt <= '0; cap <= '0;
    end else if (tick) begin
      case (state)
        S_IDLE: if (chg && !s1) begin
          state <= S_RUN; idx <= '0; cnt <= '0;
        end
        S_RUN: begin
          if (idx[0] && cinc == 8'hFF) begin
            cap[{idx, 3'b000} +: 8] <= 8'hFF;
            idx   <= idx + 1'b1;
            wcnt  <= '0;
            state <= S_WAIT;
          end else if (chg) begin
            cap[{idx, 3'b000} +: 8] <= cinc;
            idx <= idx + 1'b1;
            cnt <= '0;
            if (last) begin
              wcnt  <= '0;
              state <= S_WAIT;
            end
          end else begin
            cnt <= cinc;
          end
        end
        S_WAIT: if (wcnt == ok_cnt) state <= S_DONE;
                else                wcnt  <= wcnt + 8'd1;
        default: ;
      endcase
    end
  end

  logic [ADDR_W-1:0] woff;
  logic [WSEL_W-1:0] wsel;
  assign woff = rd_addr - A_CAP;
  assign wsel = woff[WSEL_W-1:0];

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: rd_data = {16'd0, ok_cnt, 6'd0, pw_on, rx_on};
      A_PER:  rd_data[PER_W-1:0] = per;
      A_FILT: rd_data[4:0] = dg;
      A_IEN:  rd_data[0] = ien;
      A_STAT: rd_data[0] = stat;
      default:
        if (rd_addr >= A_CAP && rd_addr < A_END)
          rd_data = cap[{wsel, 5'b00000} +: 32];
    endcase
  end

  logic unused_ok;
  assign unused_ok = ^{wr_data[31:16], woff};
endmodule

// File: rtl/ir_capture_chk.sv
module ir_capture_chk #(
  parameter int NENT  = 68,
  parameter int IDX_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              restart_wr,
  input logic              clr_wr,
  input logic              stat,
  input logic [1:0]        state,
  input logic [IDX_W-1:0]  idx,
  input logic [8*NENT-1:0] cap
);
  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state[1] && !restart_wr) |=> $stable(cap)); // R8
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart_wr |=> (cap == '0 && idx == '0 && state == 2'd0)); // R9
  AST_STAT_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat) |-> state == 2'd3); // R6
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IDX_W'(NENT)); // R7
  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart_wr) |=> ($stable(idx) && $stable(state) && $stable(cap))); // R12
  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && state != 2'd2) |=> !stat); // R10
endmodule

bind ir_capture ir_capture_chk #(.NENT(NENT), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .restart_wr(restart_wr), .clr_wr(clr_wr),
  .stat(stat), .state(state), .idx(idx), .cap(cap)
);

// File: tb/ir_capture_bench.sv
module ir_capture_bench;
  localparam int TP = 4;
  logic clk = 1'b0, rst_n = 1'b0, ir_in = 1'b1, wr_en = 1'b0;
  logic [5:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic irq;
  int compared = 0, mismatched = 0;
  bit finished = 0;

  ir_capture u_ir_capture (.clk(clk), .rst_n(rst_n), .ir_in(ir_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic seg(input logic lvl, input int n);
    ir_in = lvl;
    repeat (n * TP) @(negedge clk);
  endtask

  task automatic wait_irq(input int maxclk);
    for (int i = 0; i < maxclk; i++) begin
      if (irq) break;
      @(negedge clk);
    end
  endtask

  task automatic cleanup();
    ir_in = 1'b1;
    wr(6'd3, 32'd1);
    wr(6'd5, 32'd1);
    repeat (4 * TP) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 6; a++) begin rd(6'(a), d); chk("R1 register", d, 32'd0); end
    rd(6'd16, d); chk("R1 capture word 0", d, 32'd0);
    rd(6'd32, d); chk("R1 capture word 16", d, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic setup();
    wr(6'd1, 32'd3);
    wr(6'd2, 32'd1);
    wr(6'd0, 32'h0000_0203);
    wr(6'd4, 32'd1);
    repeat (4 * TP) @(negedge clk);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    seg(0, 10); seg(1, 5); seg(0, 20); seg(1, 7); seg(0, 3);
    seg(1, 100);
    chk("R6 no early irq", {31'd0, irq}, 32'd0);
    wait_irq(400 * TP);
    chk("R5 irq after end", {31'd0, irq}, 32'd1);
    rd(6'd16, d); chk("R2 R3 word0 widths", d, 32'h0714_050A);
    rd(6'd17, d); chk("R5 final 0xFF entry", d, 32'h0000_FF03);
    rd(6'd18, d); chk("R3 unused word zero", d, 32'd0);
  endtask

  task automatic t_hold_restart();
    logic [31:0] d;
    seg(0, 5); seg(1, 5); seg(0, 5); seg(1, 10);
    rd(6'd16, d); chk("R8 word0 held", d, 32'h0714_050A);
    rd(6'd17, d); chk("R8 word1 held", d, 32'h0000_FF03);
    rd(6'd18, d); chk("R8 word2 held", d, 32'd0);
    wr(6'd3, 32'd1);
    for (int w = 0; w < 17; w++) begin rd(6'(16 + w), d); chk("R9 cleared word", d, 32'd0); end
    chk("R9 status kept", {31'd0, irq}, 32'd1);
    wr(6'd5, 32'd1);
    chk("R10 irq cleared", {31'd0, irq}, 32'd0);
    rd(6'd5, d); chk("R10 status cleared", d, 32'd0);
    cleanup();
  endtask

  task automatic t_mark_sat();
    logic [31:0] d;
    seg(0, 300); seg(1, 4); seg(0, 2); seg(1, 1);
    wait_irq(400 * TP);
    rd(6'd16, d); chk("R4 mark clamp", d, 32'hFF02_04FF);
    cleanup();
  endtask

  task automatic t_glitch();
    logic [31:0] d;
    wr(6'd2, 32'd3);
    seg(0, 5); seg(1, 1); seg(0, 6); seg(1, 6); seg(0, 5); seg(1, 1);
    wait_irq(400 * TP);
    rd(6'd16, d); chk("R11 glitch ignored", d, 32'hFF05_060C);
    wr(6'd2, 32'd1);
    cleanup();
  endtask

  task automatic t_okcount();
    logic [31:0] d;
    wr(6'd0, 32'h0000_6403);
    seg(0, 4); seg(1, 305);
    chk("R6 completion delayed", {31'd0, irq}, 32'd0);
    rd(6'd16, d); chk("R5 end stored before completion", d, 32'h0000_FF04);
    seg(1, 100);
    chk("R6 completion after K ticks", {31'd0, irq}, 32'd1);
    wr(6'd0, 32'h0000_0203);
    cleanup();
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    for (int p = 0; p < 34; p++) begin seg(0, 2); seg(1, 3); end
    seg(0, 5); seg(1, 1);
    wait_irq(100 * TP);
    chk("R7 irq on full", {31'd0, irq}, 32'd1);
    for (int w = 0; w < 17; w++) begin rd(6'(16 + w), d); chk("R7 full word", d, 32'h0302_0302); end
    cleanup();
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(6'd4, 32'd0);
    seg(0, 6); seg(1, 300);
    chk("R10 masked irq", {31'd0, irq}, 32'd0);
    rd(6'd5, d); chk("R10 status set", d, 32'd1);
    wr(6'd4, 32'd1);
    chk("R10 irq after unmask", {31'd0, irq}, 32'd1);
    cleanup();
  endtask

  task automatic t_enables();
    logic [31:0] d;
    wr(6'd0, 32'h0000_0201);
    seg(0, 5); seg(1, 5); seg(0, 5); seg(1, 300);
    rd(6'd16, d); chk("R12 width-detect off", d, 32'd0);
    chk("R12 no irq width-detect off", {31'd0, irq}, 32'd0);
    wr(6'd0, 32'h0000_0202);
    seg(0, 5); seg(1, 5); seg(0, 5); seg(1, 300);
    rd(6'd16, d); chk("R12 receiver off", d, 32'd0);
    chk("R12 no irq receiver off", {31'd0, irq}, 32'd0);
    wr(6'd0, 32'h0000_0203);
    seg(0, 7); seg(1, 300);
    rd(6'd16, d); chk("R12 runs when both on", d, 32'h0000_FF07);
    cleanup();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    setup();
    t_basic();
    t_hold_restart();
    t_mark_sat();
    t_glitch();
    t_okcount();
    t_overflow();
    t_mask();
    t_enables();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule